// File: doc/BRIEF.md
# Latency-Compensated Second-Order Timing Loop

This block is the numeric core of a symbol timing-recovery loop for one read channel. On every symbol strobe it takes a signed sampled-phase observation and updates two estimates: the sampling phase and the frequency offset. A proportional-plus-integral filter drives a wrapping phase accumulator, which plays the part of the oscillator. The filter only sees a phase error that is N symbols stale. N is set per reset and models the latency of the detector and interpolator around the loop.

Loop latency erodes stability and magnitude response. To counter it, the block can add a correction to the stale error when compensation is on. The correction is the phase estimate from N symbols back, minus the current phase estimate, plus the sum of the last N frequency estimates. The loop then behaves close to a loop with no latency. With compensation off the correction is zero, and the block is a plain second-order loop with N symbols of latency. The proportional and integral gains are power-of-two right shifts that can be set at run time.

Top module: `dcpll`

## Requirements
- R1: A synchronous active-low reset clears the phase and frequency estimates and every history stage. phase_est and freq_est read 0 after the first clock edge with rst_n low.
- R2: While sym_en is low, phase_est and freq_est hold their values. y_in and comp_en are ignored and no history advances, so the next symbols continue as if the idle cycles had not occurred.
- R3: The filter input for symbol k uses the error of symbol k-N. After reset, phase_est and freq_est stay 0 for the first N symbols. With N=12, y_in=1000 constant, kp_shift=6 and ki_shift=13, symbol N+1 gives phase_est=15 and freq_est=500.
- R4: N is captured from dly_cfg on every clock edge where rst_n is low. A value of 0 becomes 1 and a value above MAX_DLY (32) becomes 32. Changes to dly_cfg after reset has been released have no effect.
- R5: The phase accumulator is 24 bits: y_in sits in the upper 12 bits and the low 12 bits are zero. The phase accumulator wraps. Let yd=y[k-N] and pd=phase[k-N], with history before reset counted as 0. The error is e = wrap24(yd·4096 − pd). Uncompensated, ein = e. The updates are phase' = wrap24(phase + (ein>>>kp_shift) + freq) and freq' = sat20(freq + (ein>>>ki_shift)). phase_est is the upper 12 bits of the accumulator; freq_est is the 20-bit signed frequency in accumulator LSBs per symbol.
- R6: With comp_en high (sampled each symbol), ein = e + wrap24(pd − phase[k]) + Σ freq[k−j] for j=0..N−1.
- R7: freq_est saturates at +524287 and −524288. Per symbol, freq_est never moves by more than 2^27 >> ki_shift.
- R8: Compensated, with N=20, kp_shift=6, ki_shift=13 and y_in=300 held constant from reset, phase_est settles within ±2 of 300 by 2500 symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures dly_cfg |
| sym_en | input | 1 | One symbol is processed on each edge where this is high |
| comp_en | input | 1 | Adds the latency correction to the filter input |
| dly_cfg | input | 6 | Loop latency N in symbols, captured during reset |
| kp_shift | input | 4 | Proportional gain as a right shift |
| ki_shift | input | 5 | Integral gain as a right shift |
| y_in | input | 12 | Signed phase observation for this symbol |
| phase_est | output | 12 | Signed phase estimate, upper bits of the accumulator |
| freq_est | output | 20 | Signed frequency-offset estimate |

## Verification
The properties assume that rst_n is held low for at least one edge before any symbol, so that the latency they compare against has been captured. They also assume dly_cfg is stable while reset is low. The frequency-step bound takes the gain shift to be the one present on the same edge as the symbol. The stimulus changes inputs only on falling clock edges and sets dly_cfg before lowering reset. It keeps the observation within the 12-bit signed range through explicit wrapping, so the bench's arithmetic model sees exactly the value the design sees.

// File: rtl/dcpll_pkg.sv
// Shared helpers for the latency-compensated timing loop.
// Assumes callers pass non-negative upper bounds.
package dcpll_pkg;

    // Bring a requested loop latency into the supported 1..hi range.
    function automatic int clamp_delay(input int raw, input int hi);
        if (raw < 1)
            return 1;
        if (raw > hi)
            return hi;
        return raw;
    endfunction

endpackage

// File: rtl/dcpll_tapline.sv
// Shift-register history with a run-time selectable tap.
// dout is the value pushed sel shift events ago; sel is expected in 1..DEPTH.
// Out-of-range sel reads zero. All stages clear on reset.
module dcpll_tapline #(
    parameter int W     = 24,
    parameter int DEPTH = 32,
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [W-1:0]     din,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     dout
);

    logic [W-1:0] stg [DEPTH];

    // Advance the history by one stage per shift event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                stg[i] <= '0;
        end else if (shift_en) begin
            stg[0] <= din;
            for (int i = 1; i < DEPTH; i++)
                stg[i] <= stg[i-1];
        end
    end

    // Select the stage that holds the value from sel shifts back.
    always_comb begin
        dout = '0;
        for (int i = 0; i < DEPTH; i++)
            if (SEL_W'(i + 1) == sel)
                dout = stg[i];
    end

endmodule

// File: rtl/dcpll_freq_window.sv
// Sliding sum of the current frequency estimate and the N-1 before it.
// The sum is kept incrementally: each symbol adds the newest value and drops
// the one leaving the window. Assumes SUM_W covers DEPTH full-scale terms.
module dcpll_freq_window #(
    parameter int FRQ_W = 20,
    parameter int DEPTH = 32,
    parameter int SEL_W = 6,
    parameter int SUM_W = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic signed [FRQ_W-1:0] nu_cur,
    input  logic [SEL_W-1:0]        sel,
    output logic signed [SUM_W-1:0] win_sum
);

    logic [FRQ_W-1:0]        nu_old;
    logic signed [SUM_W-1:0] tail_q;

    dcpll_tapline #(
        .W     (FRQ_W),
        .DEPTH (DEPTH),
        .SEL_W (SEL_W)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (nu_cur),
        .sel      (sel),
        .dout     (nu_old)
    );

    // Window over nu[k]..nu[k-N+1]: stored older part plus newest minus leaving.
    assign win_sum = tail_q + SUM_W'(nu_cur) - SUM_W'($signed(nu_old));

    // The window now becomes the older part for the next symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tail_q <= '0;
        else if (shift_en)
            tail_q <= win_sum;
    end

endmodule

// File: rtl/dcpll_loop_core.sv
// Proportional-plus-integral filter feeding a wrapping phase accumulator.
// The integral branch is the frequency estimate: a saturating register. The
// accumulator adds the proportional term plus that register each symbol.
// Assumes ein is already the full filter input.
module dcpll_loop_core #(
    parameter int ACC_W = 24,
    parameter int FRQ_W = 20,
    parameter int EW    = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_en,
    input  logic signed [EW-1:0]    ein,
    input  logic [3:0]              kp_shift,
    input  logic [4:0]              ki_shift,
    output logic signed [ACC_W-1:0] phi_q,
    output logic signed [FRQ_W-1:0] nu_q
);

    localparam logic signed [EW-1:0] F_HI = (EW'(1) <<< (FRQ_W - 1)) - EW'(1);
    localparam logic signed [EW-1:0] F_LO = -F_HI - EW'(1);

    logic signed [EW-1:0]    ph_step;
    logic signed [EW-1:0]    fr_sum;
    logic signed [FRQ_W-1:0] nu_n;

    assign ph_step = (ein >>> kp_shift) + EW'(nu_q);
    assign fr_sum  = (ein >>> ki_shift) + EW'(nu_q);

    // Clip the integrator to the frequency register range.
    always_comb begin
        if (fr_sum > F_HI)
            nu_n = F_HI[FRQ_W-1:0];
        else if (fr_sum < F_LO)
            nu_n = F_LO[FRQ_W-1:0];
        else
            nu_n = fr_sum[FRQ_W-1:0];
    end

    // Update phase (wrapping) and frequency once per symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phi_q <= '0;
            nu_q  <= '0;
        end else if (sym_en) begin
            phi_q <= phi_q + ph_step[ACC_W-1:0];
            nu_q  <= nu_n;
        end
    end

endmodule

// File: rtl/dcpll.sv
// Second-order timing loop with N symbols of modelled latency and optional
// latency correction. The observation and phase histories rebuild the stale
// error. The phase history and a sliding frequency sum form the correction.
// Assumes dly_cfg is stable while rst_n is low.
module dcpll
    import dcpll_pkg::*;
#(
    parameter  int PH_W    = 12,
    parameter  int FRAC_W  = 12,
    parameter  int FRQ_W   = 20,
    parameter  int MAX_DLY = 32,
    localparam int DLY_W   = $clog2(MAX_DLY + 1),
    localparam int ACC_W   = PH_W + FRAC_W,
    localparam int SUM_W   = FRQ_W + $clog2(MAX_DLY) + 1,
    localparam int EW      = ((SUM_W > ACC_W) ? SUM_W : ACC_W) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_en,
    input  logic             comp_en,
    input  logic [DLY_W-1:0] dly_cfg,
    input  logic [3:0]       kp_shift,
    input  logic [4:0]       ki_shift,
    input  logic [PH_W-1:0]  y_in,
    output logic [PH_W-1:0]  phase_est,
    output logic [FRQ_W-1:0] freq_est
);

    logic [DLY_W-1:0]        dly_q;
    logic signed [ACC_W-1:0] phi_q;
    logic signed [FRQ_W-1:0] nu_q;
    logic [PH_W-1:0]         y_d;
    logic [ACC_W-1:0]        ph_d;
    logic signed [SUM_W-1:0] nu_win;
    logic signed [ACC_W-1:0] y_dx;
    logic signed [ACC_W-1:0] err_d;
    logic signed [ACC_W-1:0] ph_gap;
    logic signed [EW-1:0]    corr;
    logic signed [EW-1:0]    ein;

    // Latch the clamped loop latency while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly_q <= DLY_W'(clamp_delay(int'(dly_cfg), MAX_DLY));
    end

    dcpll_tapline #(
        .W     (PH_W),
        .DEPTH (MAX_DLY),
        .SEL_W (DLY_W)
    ) u_obs_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sym_en),
        .din      (y_in),
        .sel      (dly_q),
        .dout     (y_d)
    );

    dcpll_tapline #(
        .W     (ACC_W),
        .DEPTH (MAX_DLY),
        .SEL_W (DLY_W)
    ) u_phase_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sym_en),
        .din      (phi_q),
        .sel      (dly_q),
        .dout     (ph_d)
    );

    dcpll_freq_window #(
        .FRQ_W (FRQ_W),
        .DEPTH (MAX_DLY),
        .SEL_W (DLY_W),
        .SUM_W (SUM_W)
    ) u_freq_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sym_en),
        .nu_cur   (nu_q),
        .sel      (dly_q),
        .win_sum  (nu_win)
    );

    // Stale error, rebuilt from the delayed observation and delayed phase.
    assign y_dx   = {y_d, {FRAC_W{1'b0}}};
    assign err_d  = y_dx - $signed(ph_d);
    // Correction: old phase minus current phase plus the recent frequency sum.
    assign ph_gap = $signed(ph_d) - phi_q;
    assign corr   = EW'(ph_gap) + EW'(nu_win);
    assign ein    = EW'(err_d) + (comp_en ? corr : '0);

    dcpll_loop_core #(
        .ACC_W (ACC_W),
        .FRQ_W (FRQ_W),
        .EW    (EW)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_en   (sym_en),
        .ein      (ein),
        .kp_shift (kp_shift),
        .ki_shift (ki_shift),
        .phi_q    (phi_q),
        .nu_q     (nu_q)
    );

    assign phase_est = phi_q[ACC_W-1 -: PH_W];
    assign freq_est  = nu_q;

endmodule

// File: rtl/dcpll_chk.sv
// Port-level properties of the timing loop, attached by bind.
// Keeps its own copy of the captured latency and a symbol count since reset.
module dcpll_chk
    import dcpll_pkg::*;
#(
    parameter int PH_W    = 12,
    parameter int FRQ_W   = 20,
    parameter int MAX_DLY = 32,
    parameter int DLY_W   = 6,
    parameter int EW      = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_en,
    input logic [DLY_W-1:0] dly_cfg,
    input logic [4:0]       ki_shift,
    input logic [PH_W-1:0]  phase_est,
    input logic [FRQ_W-1:0] freq_est
);

    int                      dly_seen;
    int                      n_sym;
    logic                    prev_en;
    logic signed [FRQ_W-1:0] prev_f;
    logic [4:0]              prev_ki;
    longint                  step_lim;
    longint                  f_delta;

    // Track captured latency, symbols since reset and the last frequency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_seen <= clamp_delay(int'(dly_cfg), MAX_DLY);
            n_sym    <= 0;
            prev_en  <= 1'b0;
            prev_f   <= '0;
            prev_ki  <= '0;
        end else begin
            if (sym_en && n_sym <= MAX_DLY)
                n_sym <= n_sym + 1;
            prev_en <= sym_en;
            prev_f  <= freq_est;
            prev_ki <= ki_shift;
        end
    end

    // Largest legal frequency move and the observed one.
    always_comb begin
        step_lim = (longint'(1) <<< (EW - 1)) >>> prev_ki;
        f_delta  = longint'($signed(freq_est)) - longint'(prev_f);
        if (f_delta < 0)
            f_delta = -f_delta;
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (phase_est == '0 && freq_est == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_en |=> ($stable(phase_est) && $stable(freq_est))); // R2

    AST_STARTUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (n_sym <= dly_seen) |-> (phase_est == '0 && freq_est == '0)); // R3

    AST_FREQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        prev_en |-> (f_delta <= step_lim)); // R7

endmodule

bind dcpll dcpll_chk #(
    .PH_W    (PH_W),
    .FRQ_W   (FRQ_W),
    .MAX_DLY (MAX_DLY),
    .DLY_W   (DLY_W),
    .EW      (EW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_en    (sym_en),
    .dly_cfg   (dly_cfg),
    .ki_shift  (ki_shift),
    .phase_est (phase_est),
    .freq_est  (freq_est)
);

// File: tb/tb_dcpll.sv
module tb_dcpll;

    localparam int PH_W    = 12;
    localparam int FRQ_W   = 20;
    localparam int MAX_DLY = 32;
    localparam int DLY_W   = 6;
    localparam int HIST    = 4200;

    typedef struct packed {
        int dly;
        int cmode;  // 0 off, 1 on, 2 toggles every 100 symbols
        int kp;
        int ki;
        int pat;
        int nsym;
    } scen_t;

    localparam scen_t SCN [7] = '{
        '{20, 1, 6, 13, 0, 600},
        '{20, 0, 6, 13, 0, 600},
        '{30, 1, 6, 13, 1, 800},
        '{30, 0, 6, 13, 1, 800},
        '{15, 1, 5, 12, 2, 600},
        '{10, 2, 6, 13, 3, 800},
        '{32, 0, 0,  0, 4, 200}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sym_en = 1'b0;
    logic             comp_en = 1'b0;
    logic [DLY_W-1:0] dly_cfg = '0;
    logic [3:0]       kp_shift = 4'd6;
    logic [4:0]       ki_shift = 5'd13;
    logic [PH_W-1:0]  y_in = '0;
    logic [PH_W-1:0]  phase_est;
    logic [FRQ_W-1:0] freq_est;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    longint y_h   [HIST];
    longint phi_h [HIST];
    longint nu_h  [HIST];
    int mk = 0;
    int mdl_n = 1;

    dcpll dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_en    (sym_en),
        .comp_en   (comp_en),
        .dly_cfg   (dly_cfg),
        .kp_shift  (kp_shift),
        .ki_shift  (ki_shift),
        .y_in      (y_in),
        .phase_est (phase_est),
        .freq_est  (freq_est)
    );

    always #5 clk = ~clk;

    function automatic longint wrapw(input longint x, input int w);
        longint m;
        m = x & ((longint'(1) <<< w) - 1);
        if (m >= (longint'(1) <<< (w - 1)))
            m = m - (longint'(1) <<< w);
        return m;
    endfunction

    function automatic longint satw(input longint x, input int w);
        longint hi;
        hi = (longint'(1) <<< (w - 1)) - 1;
        if (x > hi) return hi;
        if (x < -hi - 1) return -hi - 1;
        return x;
    endfunction

    function automatic int pat_y(input int pat, input int k);
        case (pat)
            0: return 300;
            1: return k * 7;
            2: return 400 + ((k * 37) % 61) - 30;
            3: return (((k / 200) % 2) != 0) ? 500 : -500;
            default: return 2047;
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Arithmetic model written from R5/R6 with explicit history sums.
    task automatic model_step(input int yv, input bit cen);
        longint yd, pd, ed, gap, sm, ein;
        y_h[mk] = wrapw(longint'(yv), PH_W);
        yd = (mk >= mdl_n) ? y_h[mk - mdl_n] : 0;
        pd = (mk >= mdl_n) ? phi_h[mk - mdl_n] : 0;
        ed = wrapw((yd <<< 12) - pd, 24);
        gap = wrapw(pd - phi_h[mk], 24);
        sm = 0;
        for (int j = 0; j < mdl_n; j++)
            if (mk - j >= 0)
                sm += nu_h[mk - j];
        ein = ed + (cen ? (gap + sm) : 0);
        phi_h[mk + 1] = wrapw(phi_h[mk] + (ein >>> int'(kp_shift)) + nu_h[mk], 24);
        nu_h[mk + 1]  = satw(nu_h[mk] + (ein >>> int'(ki_shift)), FRQ_W);
        mk++;
    endtask

    task automatic do_reset(input int d);
        @(negedge clk);
        rst_n = 1'b0;
        sym_en = 1'b0;
        dly_cfg = DLY_W'(d);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdl_n = (d < 1) ? 1 : ((d > MAX_DLY) ? MAX_DLY : d);
        mk = 0;
        phi_h[0] = 0;
        nu_h[0] = 0;
    endtask

    // One symbol: drive at a falling edge, compare at the next falling edge.
    task automatic run_sym(input int yv, input bit cen, input string rq);
        longint ep, ef, ap, af;
        y_in = yv[PH_W-1:0];
        comp_en = cen;
        sym_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sym_en = 1'b0;
        model_step(yv, cen);
        ep = phi_h[mk] >>> 12;
        ef = nu_h[mk];
        ap = longint'($signed(phase_est));
        af = longint'($signed(freq_est));
        check(ap == ep, rq, ap, ep);
        check(af == ef, rq, af, ef);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        bit hit;
        longint p0, f0, ap;

        // Table-driven runs against the model (R5, R6, R7).
        for (int s = 0; s < 7; s++) begin
            kp_shift = 4'(SCN[s].kp);
            ki_shift = 5'(SCN[s].ki);
            do_reset(SCN[s].dly);
            hit = 1'b0;
            for (int k = 0; k < SCN[s].nsym; k++) begin
                bit cen;
                cen = (SCN[s].cmode == 2) ? (((k / 100) % 2) != 0) : (SCN[s].cmode != 0);
                run_sym(pat_y(SCN[s].pat, k), cen, cen ? "R6" : "R5");
                if ($signed(freq_est) == 524287 || $signed(freq_est) == -524288)
                    hit = 1'b1;
            end
            if (SCN[s].pat == 4)
                check(hit, "R7 saturation reached", longint'(hit), 1);
        end

        // R1: reset after a saturated run clears outputs.
        do_reset(20);
        check(phase_est == '0, "R1 phase", longint'($signed(phase_est)), 0);
        check(freq_est == '0, "R1 freq", longint'($signed(freq_est)), 0);

        // R2: idle cycles hold outputs and leave history untouched.
        kp_shift = 4'd6;
        ki_shift = 5'd13;
        do_reset(20);
        for (int k = 0; k < 60; k++)
            run_sym(300 + k, 1'b1, "R2");
        p0 = longint'($signed(phase_est));
        f0 = longint'($signed(freq_est));
        for (int c = 0; c < 6; c++) begin
            y_in = PH_W'(c * 311);
            comp_en = c[0];
            @(negedge clk);
            check(longint'($signed(phase_est)) == p0, "R2 phase hold", longint'($signed(phase_est)), p0);
            check(longint'($signed(freq_est)) == f0, "R2 freq hold", longint'($signed(freq_est)), f0);
        end
        for (int k = 0; k < 40; k++)
            run_sym(360 + k, 1'b1, "R2 resume");

        // R3: quiet for N symbols, then a known first step.
        do_reset(12);
        for (int k = 0; k < 12; k++)
            run_sym(1000, 1'b1, "R3 quiet");
        check($signed(phase_est) == 0, "R3 still zero at N", longint'($signed(phase_est)), 0);
        run_sym(1000, 1'b1, "R3");
        check($signed(phase_est) == 15, "R3 first phase", longint'($signed(phase_est)), 15);
        check($signed(freq_est) == 500, "R3 first freq", longint'($signed(freq_est)), 500);

        // R4: dly_cfg changed after reset is ignored.
        do_reset(20);
        dly_cfg = 6'd5;
        for (int k = 0; k < 20; k++)
            run_sym(1000, 1'b1, "R4 late change");
        check($signed(phase_est) == 0, "R4 held latency", longint'($signed(phase_est)), 0);
        run_sym(1000, 1'b1, "R4");
        check($signed(phase_est) == 15, "R4 first move", longint'($signed(phase_est)), 15);

        // R4: zero clamps to one symbol.
        do_reset(0);
        run_sym(1000, 1'b0, "R4 low clamp");
        check($signed(phase_est) == 0, "R4 low clamp quiet", longint'($signed(phase_est)), 0);
        run_sym(1000, 1'b0, "R4 low clamp");
        check($signed(phase_est) == 15, "R4 low clamp move", longint'($signed(phase_est)), 15);

        // R4: oversize clamps to MAX_DLY.
        do_reset(63);
        for (int k = 0; k < 32; k++)
            run_sym(1000, 1'b1, "R4 high clamp");
        check($signed(phase_est) == 0, "R4 high clamp quiet", longint'($signed(phase_est)), 0);
        run_sym(1000, 1'b1, "R4 high clamp");
        check($signed(phase_est) == 15, "R4 high clamp move", longint'($signed(phase_est)), 15);

        // R8: compensated loop settles on a step.
        do_reset(20);
        for (int k = 0; k < 2500; k++)
            run_sym(300, 1'b1, "R8 track");
        ap = longint'($signed(phase_est));
        check(ap >= 298 && ap <= 302, "R8 settled", ap, 300);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule